// File: doc/BRIEF.md
# Dual-Clock Width-Doubling FIFO

This block moves data between two unrelated clock domains and doubles its width on the way. The producer pushes 32-bit words on its own clock. The consumer pops 64-bit words on a second clock. Each 64-bit word is made of two consecutive producer words. A full flag on the producer side and an empty flag on the consumer side give flow control. Both flags are derived from binary pointers that cross the domain boundary as Gray codes through two-stage synchronizers.

The storage is an inferred array of 32 words of 32 bits. The producer addresses it with a 5-bit write address. The consumer sees it as 16 pairs through a 4-bit read address. The read pointer counts pairs and is compared with the write pointer shifted down by one bit. As a result, a pair becomes visible to the consumer only after both of its halves have been written.

Every input to the storage array comes from a register. A push is staged for one write-clock cycle before it lands in the array. The write pointer published to the read domain moves in the same cycle as that landing.

Each domain has its own active-low asynchronous reset, and its release is resynchronized inside the block.

Top module: `width_doubler_fifo`

## Requirements
- R1: Within a pair, the word pushed first appears in rd_data[31:0] and the word pushed second appears in rd_data[63:32]. Pushing 0x00000000 then 0x00000001 pops as 0x0000000100000000.
- R2: Pushed words 2k and 2k+1 always form popped word k. Order is preserved with no slip, and the first word pushed after reset is delivered.
- R3: When an odd number of words has been pushed, the final unpaired word never clears rd_empty. The flag stays 1 until its partner arrives.
- R4: The block holds 32 pushed words. wr_full rises once 32 unread words are held. A push while wr_full is 1 is discarded and changes no stored data. wr_full returns to 0 once pairs have been popped.
- R5: A pop request while rd_empty is 1 is ignored, and rd_data keeps its previous value.
- R6: A pop is accepted on a rising rd_clk edge when rd_en is 1 and rd_empty is 0. The popped word is on rd_data right after that edge and stays there until the next accepted pop.
- R7: While its reset is low, each domain shows its reset state: wr_full is 0, rd_empty is 1 and rd_data is 0.
- R8: The flags are conservative. wr_full is 0 only when fewer than 32 words are unread. rd_empty is 0 only when at least one complete pair is unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| wr_full | output | 1 | No room for another word; pushes are discarded |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| rd_en | input | 1 | Pop request |
| rd_data | output | 64 | Last popped pair, first word in the low half |
| rd_empty | output | 1 | No complete pair available |

## Verification
The embedded properties rely on the two resets being asserted together, so that the pointers in both domains start from zero at the same time. The bench therefore holds wr_rst_n and rd_rst_n low together for several cycles of each clock before releasing them. The properties also expect wr_en and rd_en to be steady around each rising edge. The stimulus changes every input only on falling clock edges. It keeps requesting pushes into a full FIFO and pops from an empty one, because those requests are legal and are themselves covered by the checks.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  // Default geometry of the width-doubling FIFO.
  parameter int unsigned WDF_IN_W        = 32; // producer word width
  parameter int unsigned WDF_WR_AW       = 5;  // producer address bits (32 words)
  parameter int unsigned WDF_SYNC_STAGES = 2;  // flops per domain crossing
endpackage

// File: rtl/wdf_rst_sync.sv
module wdf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  // Assertion is asynchronous, release walks through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/wdf_ptr_sync.sv
module wdf_ptr_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  assign stage_d[0] = gray_in;

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_link
      assign stage_d[s] = stage_q[s-1];
    end
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign gray_out = stage_q[STAGES-1];
endmodule

// File: rtl/wdf_dp_mem.sv
module wdf_dp_mem #(
  parameter int unsigned IN_W = 32,
  parameter int unsigned AW   = 5
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [IN_W-1:0]   wdata,
  input  logic [AW-2:0]     raddr,
  output logic [2*IN_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned RATIO = 2;

  logic [IN_W-1:0] mem [DEPTH];

  // All write-port inputs arrive from registers in the write controller.
  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Lane l of a pair lives at the even/odd word of that pair.
  genvar l;
  generate
    for (l = 0; l < RATIO; l++) begin : g_lane
      assign rdata[l*IN_W +: IN_W] = mem[{raddr, 1'(l)}];
    end
  endgenerate
endmodule

// File: rtl/wdf_wr_ctrl.sv
module wdf_wr_ctrl #(
  parameter int unsigned IN_W = 32,
  parameter int unsigned AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IN_W-1:0] wr_data,
  input  logic [AW-1:0]   rgray_sync,
  output logic            full,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [IN_W-1:0] mem_wdata,
  output logic [AW:0]     wgray
);
  localparam int unsigned PW    = AW + 1; // word pointer with wrap bit
  localparam int unsigned RPW   = AW;     // pair pointer with wrap bit
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0]   wbin_q, wbin_d;
  logic [PW-1:0]   wgray_q, wgray_d;
  logic            full_q, full_d;
  logic            accept;
  logic [RPW-1:0]  rbin_sync;
  logic [PW-1:0]   rscaled;
  logic            we_q;
  logic [AW-1:0]   waddr_q;
  logic [IN_W-1:0] wdata_q;

  always_comb begin
    for (int i = 0; i < RPW; i++) rbin_sync[i] = ^(rgray_sync >> i);
    rscaled = {rbin_sync, 1'b0};
    accept  = wr_en & ~full_q;
    wbin_d  = wbin_q + {{(PW-1){1'b0}}, accept};
    full_d  = (wbin_d[PW-1] != rscaled[PW-1]) &&
              (wbin_d[PW-2:0] == rscaled[PW-2:0]);
    // Published pointer trails by one cycle, matching the staged write.
    wgray_d = wbin_q ^ (wbin_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      we_q    <= accept;
      if (accept) waddr_q <= wbin_q[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (accept) wdata_q <= wr_data;
  end

  assign full      = full_q;
  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign wgray     = wgray_q;

  logic [PW-1:0] wocc;
  assign wocc = wbin_q - rscaled;

  AST_FULL_FREEZES_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(wbin_q)); // R4
  AST_WPTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wbin_q == $past(wbin_q)) || (wbin_q == $past(wbin_q) + PW'(1))); // R2
  AST_WR_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    wocc <= PW'(DEPTH)); // R4
  AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(wgray_q ^ $past(wgray_q)) <= 1); // R8
endmodule

// File: rtl/wdf_rd_ctrl.sv
module wdf_rd_ctrl #(
  parameter int unsigned IN_W = 32,
  parameter int unsigned AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW:0]       wgray_sync,
  output logic [AW-2:0]     mem_raddr,
  input  logic [2*IN_W-1:0] mem_rdata,
  output logic [2*IN_W-1:0] rd_data,
  output logic              empty,
  output logic [AW-1:0]     rgray
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned RPW   = AW;
  localparam int unsigned PAIRS = 1 << (AW - 1);

  logic [RPW-1:0]    rbin_q, rbin_d;
  logic [RPW-1:0]    rgray_q, rgray_d;
  logic              empty_q, empty_d;
  logic              accept;
  logic [2*IN_W-1:0] rd_data_q;
  logic [PW-1:0]     wbin_sync;
  logic [RPW-1:0]    occ;

  always_comb begin
    accept  = rd_en & ~empty_q;
    rbin_d  = rbin_q + {{(RPW-1){1'b0}}, accept};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    // Gray of (word pointer >> 1) equals the Gray word pointer shifted.
    empty_d = (rgray_d == wgray_sync[PW-1:1]);
    for (int i = 0; i < PW; i++) wbin_sync[i] = ^(wgray_sync >> i);
    occ     = wbin_sync[PW-1:1] - rbin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      empty_q   <= 1'b1;
      rd_data_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
      if (accept) rd_data_q <= mem_rdata;
    end
  end

  assign mem_raddr = rbin_q[RPW-2:0];
  assign rd_data   = rd_data_q;
  assign empty     = empty_q;
  assign rgray     = rgray_q;

  AST_EMPTY_FREEZES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |=> $stable(rbin_q) && $stable(rd_data_q)); // R5
  AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= RPW'(PAIRS)); // R8
  AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(rgray_q ^ $past(rgray_q)) <= 1); // R8
endmodule

// File: rtl/width_doubler_fifo.sv
module width_doubler_fifo #(
  parameter int unsigned IN_W        = wdf_pkg::WDF_IN_W,
  parameter int unsigned AW          = wdf_pkg::WDF_WR_AW,
  parameter int unsigned SYNC_STAGES = wdf_pkg::WDF_SYNC_STAGES
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [IN_W-1:0]   wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [2*IN_W-1:0] rd_data,
  output logic              rd_empty
);
  logic            wr_rst_s_n, rd_rst_s_n;
  logic [AW:0]     wgray, wgray_rd;
  logic [AW-1:0]   rgray, rgray_wr;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [IN_W-1:0] mem_wdata;
  logic [AW-2:0]   mem_raddr;
  logic [2*IN_W-1:0] mem_rdata;

  wdf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(wr_rst_n), .rst_n(wr_rst_s_n));
  wdf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rd_rst_n), .rst_n(rd_rst_s_n));

  wdf_wr_ctrl #(.IN_W(IN_W), .AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .wr_en(wr_en), .wr_data(wr_data),
    .rgray_sync(rgray_wr), .full(wr_full), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray));

  wdf_ptr_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .gray_in(wgray), .gray_out(wgray_rd));
  wdf_ptr_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .gray_in(rgray), .gray_out(rgray_wr));

  wdf_dp_mem #(.IN_W(IN_W), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  wdf_rd_ctrl #(.IN_W(IN_W), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .rd_en(rd_en), .wgray_sync(wgray_rd),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .rd_data(rd_data),
    .empty(rd_empty), .rgray(rgray));
endmodule

// File: tb/tb_width_doubler_fifo.sv
module tb_width_doubler_fifo;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n, rd_rst_n, wr_en, rd_en, wr_full, rd_empty;
  logic [31:0] wr_data;
  logic [63:0] rd_data;

  always #(WCLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

  width_doubler_fifo dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty));

  // Behavioural reference: queue of unread words, last popped pair.
  int          checks = 0, fails = 0, pairs_read = 0;
  bit          last_acc, finished = 1'b0;
  logic [31:0] q[$];
  logic [63:0] exp_rd;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // One write-clock cycle: flags are sampled at the falling edge, where
  // they already hold the value the next rising edge will see.
  task automatic wr_cycle(input bit en, input logic [31:0] d);
    @(negedge wr_clk);
    if (!wr_full) chk(q.size() < 32, "R8 full low only with room", 64'(q.size()), 64'd31);
    last_acc = en && !wr_full;
    if (last_acc) q.push_back(d);
    wr_en   = en;
    wr_data = d;
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rd_clk);
    chk(rd_data === exp_rd, "R2 R6 popped word", rd_data, exp_rd);
    if (!rd_empty) chk(q.size() >= 2, "R8 empty low only with a pair", 64'(q.size()), 64'd2);
    if (en && !rd_empty && q.size() >= 2) begin
      exp_rd = {q[1], q[0]};
      void'(q.pop_front());
      void'(q.pop_front());
      pairs_read++;
    end
    rd_en = en;
  endtask

  initial begin
    #(WCLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; exp_rd = '0;
    repeat (4) @(negedge rd_clk);
    chk(wr_full == 1'b0, "R7 full after reset", 64'(wr_full), 64'd0);
    chk(rd_empty == 1'b1, "R7 empty after reset", 64'(rd_empty), 64'd1);
    chk(rd_data == 64'd0, "R7 data after reset", rd_data, 64'd0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (4) wr_cycle(1'b0, '0);
    repeat (4) rd_cycle(1'b0);

    // R3: a lone word never exposes a pair; pops meanwhile are ignored (R5).
    wr_cycle(1'b1, 32'h0000_0000);
    wr_cycle(1'b0, '0);
    repeat (30) begin
      rd_cycle(1'b1);
      chk(rd_empty == 1'b1, "R3 unpaired word keeps empty", 64'(rd_empty), 64'd1);
    end
    wr_cycle(1'b1, 32'h0000_0001);
    wr_cycle(1'b0, '0);
    for (int n = 0; n < 100 && pairs_read < 1; n++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk(rd_data == 64'h0000_0001_0000_0000, "R1 first word in low half",
        rd_data, 64'h0000_0001_0000_0000);

    // R2: concurrent streaming with irregular gaps on both sides.
    fork
      begin
        for (int i = 0; i < 120; i++) begin
          do wr_cycle(1'b1, 32'hA500_0000 + 32'(i)); while (!last_acc);
          repeat ($urandom_range(0, 2)) wr_cycle(1'b0, '0);
        end
        wr_cycle(1'b0, '0);
      end
      begin
        for (int n = 0; n < 5000 && pairs_read < 61; n++)
          rd_cycle($urandom_range(0, 9) < 7);
        rd_cycle(1'b0);
      end
    join
    chk(pairs_read == 61, "R2 every pair delivered", 64'(pairs_read), 64'd61);

    // R4: fill past capacity with the reader idle.
    repeat (10) rd_cycle(1'b0);
    repeat (6) wr_cycle(1'b0, '0);
    chk(q.size() == 0, "R2 stream fully drained", 64'(q.size()), 64'd0);
    for (int i = 0; i < 40; i++) wr_cycle(1'b1, 32'hC000_0000 + 32'(i));
    wr_cycle(1'b0, '0);
    chk(wr_full == 1'b1, "R4 full at capacity", 64'(wr_full), 64'd1);
    chk(q.size() == 32, "R4 exactly 32 words accepted", 64'(q.size()), 64'd32);

    // Drain; discarded pushes must not appear (R4), then R5 pops on empty.
    for (int n = 0; n < 500 && pairs_read < 77; n++) rd_cycle(1'b1);
    repeat (10) rd_cycle(1'b1);
    chk(rd_data == {32'hC000_001F, 32'hC000_001E}, "R5 data held on empty pop",
        rd_data, {32'hC000_001F, 32'hC000_001E});
    chk(rd_empty == 1'b1, "R8 empty after drain", 64'(rd_empty), 64'd1);
    rd_cycle(1'b0);
    repeat (8) wr_cycle(1'b0, '0);
    chk(wr_full == 1'b0, "R4 full clears after drain", 64'(wr_full), 64'd0);
    summary();
  end
endmodule